// File: doc/BRIEF.md
# Serial Flash Boot Streamer

This block lets an FPGA in serial-master configuration mode load its bitstream from a plain serial flash. The clock that the FPGA drives out for configuration feeds the block, and the block passes that same clock straight to the flash. The block therefore needs no oscillator of its own.

After reset the block selects the flash and sends a read command, followed by a start address. It then forwards every bit the flash returns to the FPGA's serial data input. This continues for as long as needed, because the bitstream length is not known in advance. When the FPGA signals that configuration is complete, the block deselects the flash and parks. Only a new reset brings it out of that parked state.

A build-time parameter sets the bit order within each byte. In reversed mode the block collects each byte in full and then sends it out in the opposite order. This allows a flash image that was written with swapped bits to be used without rewriting it.

Top module: `spi_cfg_bridge`

## Requirements
- R1: While `rst` is high, `fl_cs_n` is 1, `cfg_din` is 0 and `fl_mosi` is 0.
- R2: On the first rising edge of `cfg_clk` with `rst` low, `fl_cs_n` goes to 0. It stays 0 through the command, address and data phases.
- R3: The block sends the read opcode 8'h03 MSB-first on `fl_mosi`, followed by a 24-bit start address MSB-first, which is 32 bits in total. `fl_mosi` changes only on falling edges of the clock.
- R4: The start address comes from the `START_ADDR` parameter, which defaults to 0.
- R5: In normal order (`LSB_FIRST`=0), the block samples `fl_miso` on each rising edge of the data phase and shows that bit on `cfg_din` right after that same edge. The first data bit appears after the 34th rising edge that follows reset release.
- R6: If `cfg_done` is 1 at a rising edge during the data phase, `fl_cs_n` is 1 and `cfg_din` is 0 right after that edge.
- R7: After R6 the block stays parked, with `fl_cs_n`=1 and `cfg_din`=0, whatever `cfg_done` does afterwards. A reset followed by release starts a new read.
- R8: `cfg_din` is 0 from reset release until the data phase begins.
- R9: `cfg_done` has no effect during the command and address phases. The read continues and `fl_cs_n` stays 0.
- R10: In reversed order (`LSB_FIRST`=1), each flash byte is sent out least significant bit first. Output bit j (the bit at weight j%8 of flash byte j/8) appears 7 cycles later than output bit j would appear in normal order. `cfg_din` is 0 until the first byte is complete.
- R11: `fl_sck` equals `cfg_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock driven by the target FPGA |
| rst | input | 1 | Synchronous reset, active high |
| cfg_done | input | 1 | Configuration-complete flag from the target FPGA |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock |
| fl_mosi | output | 1 | Serial data to the flash |
| fl_miso | input | 1 | Serial data from the flash |
| cfg_din | output | 1 | Serial bitstream to the FPGA configuration input |

## Verification
The hardest cases to reach from the ports are a completion flag that arrives while the command is still being sent, and the byte boundary in reversed mode, where zeros must give way to the first full reversed byte on exactly the right edge. The bench raises `cfg_done` for one cycle in the middle of the opcode. It then confirms that chip select stays low and that the flash model still receives all 32 command bits. For the reversed instance, the bench walks a byte table and checks every output bit against a 7-cycle offset, including the seven leading zeros.

// File: rtl/spi_cfg_bridge.sv
module spi_cfg_bridge #(
  parameter logic [23:0] START_ADDR = 24'h000000,
  parameter logic [7:0]  READ_OPC   = 8'h03,
  parameter bit          LSB_FIRST  = 1'b0
) (
  input  logic cfg_clk,
  input  logic rst,
  input  logic cfg_done,
  output logic fl_cs_n,
  output logic fl_sck,
  output logic fl_mosi,
  input  logic fl_miso,
  output logic cfg_din
);

  localparam int          CMD_W    = 8 + 24;
  localparam logic [4:0]  OPC_LAST = 5'd7;
  localparam logic [4:0]  ADR_LAST = 5'd23;
  localparam logic [CMD_W-1:0] CMD = {READ_OPC, START_ADDR};

  typedef enum logic [2:0] {S_RST, S_OPC, S_ADR, S_RD, S_WAIT} st_t;

  st_t        st;
  logic [4:0] cnt;
  logic [2:0] bcnt;
  logic [7:0] col, osh;
  logic       din_q, mosi_q;
  logic [4:0] idx;

  assign idx     = (st == S_OPC) ? cnt : cnt + 5'd8;
  assign fl_sck  = cfg_clk;
  assign fl_mosi = mosi_q;
  assign fl_cs_n = !(st == S_OPC || st == S_ADR || st == S_RD);
  assign cfg_din = (st == S_RD) && (LSB_FIRST ? osh[0] : din_q);

  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      st    <= S_RST;
      cnt   <= '0;
      bcnt  <= '0;
      col   <= '0;
      osh   <= '0;
      din_q <= 1'b0;
    end else begin
      case (st)
        S_RST: begin
          st  <= S_OPC;
          cnt <= '0;
        end
        S_OPC: begin
          if (cnt == OPC_LAST) begin
            st  <= S_ADR;
            cnt <= '0;
          end else cnt <= cnt + 5'd1;
        end
        S_ADR: begin
          if (cnt == ADR_LAST) begin
            st    <= S_RD;
            cnt   <= '0;
            bcnt  <= '0;
            osh   <= '0;
            din_q <= 1'b0;
          end else cnt <= cnt + 5'd1;
        end
        S_RD: begin
          if (cfg_done) st <= S_WAIT;
          else begin
            din_q <= fl_miso;
            col   <= {col[6:0], fl_miso};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) osh <= {col[6:0], fl_miso};
            else              osh <= {1'b0, osh[7:1]};
          end
        end
        S_WAIT: st <= S_WAIT;
        default: st <= S_RST;
      endcase
    end
  end

  always_ff @(negedge cfg_clk) begin
    if (rst) mosi_q <= 1'b0;
    else     mosi_q <= (st == S_OPC || st == S_ADR) ? CMD[5'd31 - idx] : 1'b0;
  end

  a_r6_done_release: assert property (@(posedge cfg_clk) disable iff (rst)
    (st == S_RD && cfg_done) |=> (fl_cs_n && !cfg_din));

  a_r7_wait_sticky: assert property (@(posedge cfg_clk) disable iff (rst)
    (st == S_WAIT) |=> (st == S_WAIT && fl_cs_n));

  a_r8_quiet_on_release: assert property (@(posedge cfg_clk) disable iff (rst)
    $rose(fl_cs_n) |-> !cfg_din);

  a_r3_opcode_len: assert property (@(posedge cfg_clk) disable iff (rst)
    (st == S_OPC && cnt == OPC_LAST) |=> (st == S_ADR && cnt == 5'd0));

  a_r9_done_ignored: assert property (@(posedge cfg_clk) disable iff (rst)
    ((st == S_OPC || st == S_ADR) && cfg_done) |=> !fl_cs_n);

  a_r2_select_held: assert property (@(posedge cfg_clk) disable iff (rst)
    (st == S_ADR) |=> !fl_cs_n);

endmodule

// File: tb/sim_spi_cfg_bridge.sv
module sim_flash #(parameter logic [63:0] IMG = '0) (
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic [31:0] cmd = '0;
  int          n   = 0;
  int          pos = 0;
  initial miso = 1'b0;
  always @(posedge sck) begin
    if (cs_n) n <= 0;
    else if (n < 32) begin
      cmd <= {cmd[30:0], mosi};
      n   <= n + 1;
    end
  end
  always @(negedge sck) begin
    if (cs_n) begin
      pos  <= 0;
      miso <= 1'b0;
    end else if (n == 32) begin
      miso <= IMG[63 - (pos % 64)];
      pos  <= pos + 1;
    end
  end
endmodule

module sim_spi_cfg_bridge;
  localparam logic [7:0] IMG [0:7] = '{8'hC3, 8'h01, 8'h80, 8'h5A, 8'hFF, 8'h00, 8'h96, 8'h3C};
  localparam logic [63:0] IMG_FLAT = {IMG[0], IMG[1], IMG[2], IMG[3], IMG[4], IMG[5], IMG[6], IMG[7]};
  localparam logic [23:0] A0 = 24'hA50F3C;

  logic clk = 0, rst = 1, done0 = 0, done1 = 0;
  logic cs0, sck0, mosi0, miso0, din0;
  logic cs1, sck1, mosi1, miso1, din1;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  spi_cfg_bridge #(.START_ADDR(A0)) u0 (.cfg_clk(clk), .rst(rst), .cfg_done(done0),
    .fl_cs_n(cs0), .fl_sck(sck0), .fl_mosi(mosi0), .fl_miso(miso0), .cfg_din(din0));
  spi_cfg_bridge #(.LSB_FIRST(1'b1)) u1 (.cfg_clk(clk), .rst(rst), .cfg_done(done1),
    .fl_cs_n(cs1), .fl_sck(sck1), .fl_mosi(mosi1), .fl_miso(miso1), .cfg_din(din1));
  sim_flash #(.IMG(IMG_FLAT)) m0 (.sck(sck0), .cs_n(cs0), .mosi(mosi0), .miso(miso0));
  sim_flash #(.IMG(IMG_FLAT)) m1 (.sck(sck1), .cs_n(cs1), .mosi(mosi1), .miso(miso1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk(cs0 && cs1, "R1 cs_n in reset", {cs0, cs1}, 2'b11);
    chk(!din0 && !din1, "R1 din in reset", {din0, din1}, 0);
    chk(!mosi0 && !mosi1, "R1 mosi in reset", {mosi0, mosi1}, 0);
    @(negedge clk); #1;
    chk(sck0 == clk && sck1 == clk, "R11 sck low phase", sck0, clk);
    rst = 0;
    for (int n = 0; n < 112; n++) begin
      step();
      if (n == 0) begin
        chk(!cs0 && !cs1, "R2 cs_n low after release", {cs0, cs1}, 0);
        chk(sck0 == 1'b1, "R11 sck high phase", sck0, 1);
      end
      if (n <= 32) chk(!din0 && !din1, "R8 din quiet in command", {din0, din1}, 0);
      if (n == 2) done1 = 1;
      if (n == 3) begin
        done1 = 0;
        chk(!cs1, "R9 done in opcode ignored", cs1, 0);
      end
      if (n == 20) chk(!cs0 && !cs1, "R2 cs_n held in address", {cs0, cs1}, 0);
      if (n == 32) begin
        chk(m0.cmd == {8'h03, A0}, "R3 R4 command with start address", m0.cmd, {8'h03, A0});
        chk(m1.cmd == {8'h03, 24'h0}, "R3 R4 command default address", m1.cmd, 32'h03000000);
      end
      if (n >= 33 && n <= 96) begin
        automatic int p = n - 33;
        chk(din0 == IMG[p / 8][7 - (p % 8)], $sformatf("R5 msb stream bit %0d", p), din0, IMG[p / 8][7 - (p % 8)]);
      end
      if (n >= 33 && n <= 39) chk(!din1, "R10 zeros before first byte", din1, 0);
      if (n >= 40 && n <= 103) begin
        automatic int j = n - 40;
        chk(din1 == IMG[j / 8][j % 8], $sformatf("R10 lsb stream bit %0d", j), din1, IMG[j / 8][j % 8]);
      end
      if (n == 50) chk(!cs0 && !cs1, "R2 cs_n held in data", {cs0, cs1}, 0);
      if (n == 100) done0 = 1;
      if (n == 101) begin
        chk(cs0 && !din0, "R6 release on done", {cs0, din0}, 2'b10);
        done0 = 0;
      end
      if (n == 104) done1 = 1;
      if (n == 105) begin
        chk(cs1 && !din1, "R6 release on done lsb", {cs1, din1}, 2'b10);
        done1 = 0;
      end
      if (n == 110) chk(cs0 && !din0 && cs1, "R7 parked after done drops", {cs0, din0, cs1}, 3'b101);
    end
    rst = 1;
    step();
    chk(cs0 && !din0, "R1 reset again", {cs0, din0}, 2'b10);
    rst = 0;
    step();
    chk(!cs0 && !cs1, "R7 restart after reset", {cs0, cs1}, 0);
    repeat (32) step();
    chk(m0.cmd == {8'h03, A0}, "R7 command resent", m0.cmd, {8'h03, A0});
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule